// File: doc/BRIEF.md
# Stream-to-Multichannel Sample Unpacker

This block takes a packed sample stream and deals its samples out to a set of parallel output channels. The input is an AXI4-Stream slave whose beats each carry one sample per channel. The output side is a read port shared by all channels. A single request strobe asks for one sample per enabled channel, and a per-channel enable mask chooses which channels take part.

Samples from accepted beats are kept in an internal store, oldest first. A request is answered exactly one clock later, by one of two flags. A valid flag means every enabled channel now holds its next sample. An underflow flag means too few samples were buffered, and nothing was consumed. Samples left over after a request stay in the store for later requests. The stream is throttled through tready, so the store never overflows. The enable mask is meant to be set while the block is held in reset and then left unchanged.

Top module: `sample_unpacker`

## Requirements
- R1: While reset is held, and on the first cycle after it is released, rdValid and rdUnderflow are low, sTready is high, and the store holds no samples.
- R2: A beat is accepted on a rising edge with sTvalid and sTready both high. Lane j of sTdata (bits j*SAMPLE_W upward) is the j-th sample of that beat in stream order.
- R3: sTready is high exactly when the store holds at most NUM_CH samples, so it always has room for one whole beat. The store never holds more than 2*NUM_CH samples.
- R4: A request (rdReq high at an edge) finds enough data when the samples buffered before that edge number at least the count of enabled channels. In that case rdValid is high for exactly the following cycle. A beat accepted on the same edge does not count toward that request.
- R5: In a valid cycle, enabled channel c carries the buffered sample whose offset from the oldest equals the number of enabled channels below c. Enabled channels therefore receive consecutive samples in ascending channel order.
- R6: A request that finds too few samples raises rdUnderflow in the following cycle and consumes no samples.
- R7: rdValid and rdUnderflow are never high together, and neither is high in a cycle that does not follow a request.
- R8: A granted request removes exactly as many samples as there are enabled channels. Leftover samples, including those split across beats, are served to later requests in stream order.
- R9: All values of the enable mask work. With an all-zero mask, every request is granted and consumes nothing.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge active |
| rstN | input | 1 | Asynchronous reset, active low |
| chanEnable | input | NUM_CH | Per-channel enable mask, bit c for channel c |
| sTvalid | input | 1 | Stream beat valid |
| sTready | output | 1 | Stream beat ready |
| sTdata | input | NUM_CH*SAMPLE_W | Stream beat, lane j holds the j-th sample |
| rdReq | input | 1 | Read request shared by all channels |
| rdValid | output | 1 | Enabled channels carry fresh samples this cycle |
| rdUnderflow | output | 1 | The previous request found too few samples |
| rdData | output | NUM_CH*SAMPLE_W | Channel c sample in bits c*SAMPLE_W upward |

## Verification
The bench builds the block with four channels of 8-bit samples. With those values, all sixteen enable masks can be swept, each one after its own reset, and every channel rank from zero to three is reachable. Samples carry their own stream serial numbers. The bench can therefore compute each expected channel value, each grant or underflow, and each ready level from running counts of samples pushed and consumed. Each sweep begins by requesting from an empty store, then interleaves beats and requests so that samples split across beats and the store fills to its limit, and then drains until underflow.

// File: rtl/unpack_pkg.sv
package unpack_pkg;

  // Strobes from the control to the datapath for one clock edge.
  typedef struct packed {
    logic take;  // a granted request removes needCount samples
    logic push;  // a stream beat is appended behind the buffered samples
  } unpackStrobe_t;

endpackage

// File: rtl/unpack_ctrl.sv
module unpack_ctrl
  import unpack_pkg::*;
#(
  parameter int NUM_CH = 4,
  localparam int DEPTH = 2 * NUM_CH,
  localparam int CW = $clog2(DEPTH + 1)
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic [NUM_CH-1:0] chanEnable,
  input  logic              sTvalid,
  output logic              sTready,
  input  logic              rdReq,
  output logic              rdValid,
  output logic              rdUnderflow,
  output unpackStrobe_t     strobe,
  output logic [CW-1:0]     fillCount,
  output logic [CW-1:0]     needCount
);

  localparam logic [CW-1:0] BEAT = CW'(NUM_CH);

  logic grant;
  logic [CW-1:0] fillNext;

  assign needCount = CW'($countones(chanEnable));
  // Room for one whole beat.
  assign sTready = (fillCount <= BEAT);
  assign grant = rdReq && (fillCount >= needCount);

  always_comb begin
    strobe.take = grant;
    strobe.push = sTvalid && sTready;
    fillNext = fillCount;
    if (strobe.take) fillNext = fillNext - needCount;
    if (strobe.push) fillNext = fillNext + BEAT;
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      fillCount   <= '0;
      rdValid     <= 1'b0;
      rdUnderflow <= 1'b0;
    end else begin
      fillCount   <= fillNext;
      rdValid     <= grant;
      rdUnderflow <= rdReq && !grant;
    end
  end

  assert_no_overflow_R3: assert property (@(posedge clk) disable iff (!rstN)
    fillCount <= CW'(DEPTH));

  assert_flags_exclusive_R7: assert property (@(posedge clk) disable iff (!rstN)
    !(rdValid && rdUnderflow));

  assert_no_flag_without_req_R7: assert property (@(posedge clk) disable iff (!rstN)
    !rdReq |=> (!rdValid && !rdUnderflow));

  assert_underflow_keeps_samples_R6: assert property (@(posedge clk) disable iff (!rstN)
    rdUnderflow |-> (fillCount >= $past(fillCount)));

  assert_exact_consumption_R8: assert property (@(posedge clk) disable iff (!rstN)
    rdValid |-> (({1'b0, fillCount} + {1'b0, $past(needCount)}) ==
                 ({1'b0, $past(fillCount)} + ($past(strobe.push) ? {1'b0, BEAT} : '0))));

endmodule

// File: rtl/unpack_datapath.sv
module unpack_datapath
  import unpack_pkg::*;
#(
  parameter int NUM_CH = 4,
  parameter int SAMPLE_W = 8,
  localparam int DEPTH = 2 * NUM_CH,
  localparam int IW = $clog2(DEPTH),
  localparam int CW = $clog2(DEPTH + 1),
  localparam int LW = $clog2(NUM_CH)
) (
  input  logic                         clk,
  input  logic [NUM_CH-1:0]            chanEnable,
  input  unpackStrobe_t                strobe,
  input  logic [CW-1:0]                fillCount,
  input  logic [CW-1:0]                needCount,
  input  logic [NUM_CH*SAMPLE_W-1:0]   sTdata,
  output logic [NUM_CH*SAMPLE_W-1:0]   rdData
);

  logic [SAMPLE_W-1:0] store    [DEPTH];
  logic [SAMPLE_W-1:0] storeNxt [DEPTH];
  logic [SAMPLE_W-1:0] beatLane [NUM_CH];
  logic [SAMPLE_W-1:0] chanReg  [NUM_CH];
  logic [IW-1:0]       rank     [NUM_CH];
  logic [CW:0]         takeAmt;

  assign takeAmt = strobe.take ? {1'b0, needCount} : '0;

  // Offset of each channel's sample: enabled channels below it.
  always_comb begin : rankCalc
    logic [IW-1:0] acc;
    acc = '0;
    for (int c = 0; c < NUM_CH; c++) begin
      rank[c] = acc;
      acc = acc + IW'(chanEnable[c]);
    end
  end

  genvar g;
  generate
    for (g = 0; g < NUM_CH; g++) begin : genLane
      assign beatLane[g] = sTdata[g*SAMPLE_W +: SAMPLE_W];

      always_ff @(posedge clk) begin
        if (strobe.take) chanReg[g] <= store[rank[g]];
      end

      assign rdData[g*SAMPLE_W +: SAMPLE_W] = chanReg[g];
    end

    // Each entry shifts down by the consumed amount and is refilled from the beat.
    for (g = 0; g < DEPTH; g++) begin : genEntry
      logic [CW:0] srcIdx;
      logic [CW:0] laneOff;

      always_comb begin
        srcIdx  = (CW+1)'(g) + takeAmt;
        laneOff = srcIdx - {1'b0, fillCount};
        if (srcIdx < {1'b0, fillCount})
          storeNxt[g] = store[srcIdx[IW-1:0]];
        else if (strobe.push && (laneOff < (CW+1)'(NUM_CH)))
          storeNxt[g] = beatLane[laneOff[LW-1:0]];
        else
          storeNxt[g] = store[g];
      end

      always_ff @(posedge clk) store[g] <= storeNxt[g];
    end
  endgenerate

endmodule

// File: rtl/sample_unpacker.sv
module sample_unpacker
  import unpack_pkg::*;
#(
  parameter int NUM_CH = 4,
  parameter int SAMPLE_W = 8
) (
  input  logic                       clk,
  input  logic                       rstN,
  input  logic [NUM_CH-1:0]          chanEnable,
  input  logic                       sTvalid,
  output logic                       sTready,
  input  logic [NUM_CH*SAMPLE_W-1:0] sTdata,
  input  logic                       rdReq,
  output logic                       rdValid,
  output logic                       rdUnderflow,
  output logic [NUM_CH*SAMPLE_W-1:0] rdData
);

  localparam int CW = $clog2(2 * NUM_CH + 1);

  unpackStrobe_t strobe;
  logic [CW-1:0] fillCount;
  logic [CW-1:0] needCount;

  unpack_ctrl #(.NUM_CH(NUM_CH)) u_ctrl (
    .clk         (clk),
    .rstN        (rstN),
    .chanEnable  (chanEnable),
    .sTvalid     (sTvalid),
    .sTready     (sTready),
    .rdReq       (rdReq),
    .rdValid     (rdValid),
    .rdUnderflow (rdUnderflow),
    .strobe      (strobe),
    .fillCount   (fillCount),
    .needCount   (needCount)
  );

  unpack_datapath #(.NUM_CH(NUM_CH), .SAMPLE_W(SAMPLE_W)) u_datapath (
    .clk        (clk),
    .chanEnable (chanEnable),
    .strobe     (strobe),
    .fillCount  (fillCount),
    .needCount  (needCount),
    .sTdata     (sTdata),
    .rdData     (rdData)
  );

endmodule

// File: tb/sample_unpacker_bench.sv
`timescale 1ns/1ps
module sample_unpacker_bench;
  localparam int NCH = 4;
  localparam int SW = 8;

  logic clk = 1'b0;
  logic rstN = 1'b0;
  logic [NCH-1:0] chanEnable = '0;
  logic sTvalid = 1'b0;
  logic sTready;
  logic [NCH*SW-1:0] sTdata = '0;
  logic rdReq = 1'b0;
  logic rdValid, rdUnderflow;
  logic [NCH*SW-1:0] rdData;

  int checks = 0;
  int fails = 0;
  int pushed, consumed;
  bit expV, expU;
  int expData [NCH];

  always #2 clk = ~clk;

  sample_unpacker #(.NUM_CH(NCH), .SAMPLE_W(SW)) u_sample_unpacker (
    .clk(clk), .rstN(rstN), .chanEnable(chanEnable),
    .sTvalid(sTvalid), .sTready(sTready), .sTdata(sTdata),
    .rdReq(rdReq), .rdValid(rdValid), .rdUnderflow(rdUnderflow), .rdData(rdData)
  );

  task automatic check(input bit ok, input string req, input string what,
                       input int act, input int exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s %s actual=%0d expected=%0d", req, what, act, exp);
    end
  endtask

  function automatic int popc(input int m);
    int n = 0;
    for (int b = 0; b < NCH; b++) n += (m >> b) & 1;
    return n;
  endfunction

  function automatic int rankOf(input int m, input int c);
    int n = 0;
    for (int b = 0; b < c; b++) n += (m >> b) & 1;
    return n;
  endfunction

  task automatic summary();
    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
    $finish;
  endtask

  initial begin
    #(200000 * 4);
    checks++;
    fails++;
    $display("FAIL watchdog expired");
    summary();
  end

  initial begin
    for (int m = 0; m < (1 << NCH); m++) begin
      @(negedge clk);
      rstN = 1'b0;
      sTvalid = 1'b0;
      rdReq = 1'b0;
      chanEnable = NCH'(m);
      repeat (2) @(negedge clk);
      // R1: flags low and ready high while in reset
      check(!rdValid && !rdUnderflow && sTready, "R1", "reset state",
            {rdValid, rdUnderflow, sTready}, 1);
      rstN = 1'b1;
      pushed = 0;
      consumed = 0;
      for (int cyc = 0; cyc < 90; cyc++) begin
        // Drive stimulus for the next rising edge.
        if (cyc < 10) begin
          sTvalid = 1'b0;
          rdReq = cyc[0];
        end else if (cyc < 70) begin
          sTvalid = ((cyc * 5 + m) % 7) < 4;
          rdReq = ((cyc * 3 + m) % 5) < 3;
        end else begin
          sTvalid = 1'b0;
          rdReq = 1'b1;
        end
        // R2: lane j carries stream sample pushed+j
        for (int j = 0; j < NCH; j++) sTdata[j*SW +: SW] = SW'(pushed + j);
        // Model of this edge: availability uses samples buffered before it (R4).
        expV = 1'b0;
        expU = 1'b0;
        if (rdReq) begin
          if (pushed - consumed >= popc(m)) begin
            expV = 1'b1;
            for (int c = 0; c < NCH; c++) expData[c] = (consumed + rankOf(m, c)) & 255;
            consumed += popc(m);
          end else begin
            expU = 1'b1;
          end
        end
        if (sTvalid && sTready) pushed += NCH;
        @(negedge clk);
        check(rdValid == expV, "R4 R7 R9", "rdValid", rdValid, expV);
        check(rdUnderflow == expU, "R6 R7", "rdUnderflow", rdUnderflow, expU);
        check(sTready == ((pushed - consumed) <= NCH), "R3", "sTready",
              sTready, (pushed - consumed) <= NCH);
        if (expV) begin
          for (int c = 0; c < NCH; c++) begin
            if (m[c]) begin
              // R5 R8 R2 R9: ascending rank, exact consumption, stream order
              check(int'(rdData[c*SW +: SW]) == expData[c], "R5 R8", "channel data",
                    int'(rdData[c*SW +: SW]), expData[c]);
            end
          end
        end
      end
    end
    summary();
  end

endmodule